// File: doc/BRIEF.md
# DRAM Data-Pin Output Path Controller

This block is the device-side control for the data pins of an extended-data-output dynamic memory. Each clock it samples the four active-low strobes: row strobe, column strobe, write strobe and output-enable. From them it decides whether the data pins are driven and whether the output latch loads new array data or keeps its value. It also loads the per-bit write mask and produces a write enable for each data bit. Analog delays are replaced by ordering at the clock edge. Every strobe edge is detected by comparing the current sample with the sample taken at the previous edge.

The output latch keeps its data after the column strobe returns high, so the pins stay valid between column accesses. The drivers stay on until both strobes have been sampled high. Output-enable and write strobe can each switch the drivers off without disturbing the latch. A parameter selects a plain fast-page variant instead, where the drivers close as soon as the column strobe is sampled high. A second parameter removes the per-bit mask, so that every bit is always writable.

Top module: `dram_io_ctl`

## Requirements
- R1: While reset is asserted and after it is released, dout_en is 0, dout is 0, wmask is all ones and bit_we is 0.
- R2: At a clock edge where cas_n is sampled low after being high, with ras_n low and we_n high, dout takes the value of rd_data sampled at that edge. From then on dout_en is 1 while oe_n is 0 and we_n is 1.
- R3: A column strobe falling edge sampled while ras_n is high does not open the path: dout_en stays 0 and dout is unchanged.
- R4: With extended hold, after cas_n is sampled high again while ras_n stays low, dout keeps its value and dout_en stays 1. Changes on rd_data have no effect.
- R5: With extended hold, the path closes at the first edge where ras_n and cas_n are both sampled high. If ras_n rises while cas_n is still low, dout_en stays 1 until cas_n is also high. The latch keeps its value after closing.
- R6: oe_n = 1 forces dout_en to 0 in the same cycle. The latch is not disturbed, so returning oe_n to 0 shows the same dout.
- R7: we_n = 0 forces dout_en to 0. Once an edge samples ras_n, cas_n and we_n all low, dout_en stays 0 until the path closes, even if we_n returns high.
- R8: If we_n is sampled low at the row strobe falling edge, pin_in is loaded into wmask at that edge. While ras_n, cas_n and we_n are all low in an active row, bit_we equals wmask (1 = write the bit, 0 = keep it). Otherwise bit_we is 0.
- R9: If we_n is sampled high at the row strobe falling edge, wmask is loaded with all ones.
- R10: At the edge where ras_n is sampled high after being low, wmask returns to all ones. The mask lasts for one row cycle only.
- R11: A column strobe falling edge sampled with we_n low does not load the output latch.
- R12: In the fast-page variant (EXT_HOLD = 0), dout_en falls at the first edge where cas_n is sampled high.
- R13: With the per-bit mask disabled (PER_BIT_EN = 0), wmask is always all ones, and a write drives bit_we to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low, already synchronous |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DW | Data read from the selected array location |
| pin_in | input | DW | Value received on the data pins |
| dout | output | DW | Output latch contents |
| dout_en | output | 1 | Tri-state enable for the data pin drivers |
| wmask | output | DW | Write mask register |
| bit_we | output | DW | Per-bit write enable to the array |

## Verification
The bench builds two copies from the same stimulus. The first uses the defaults: DW = 8, extended hold, per-bit mask on. It reaches the hold-after-column-rise path, the row-first and column-first closing orders, and the masked write. The second has EXT_HOLD = 0 and PER_BIT_EN = 0. It checks against the same sequence that the drivers close when the column strobe rises and that the mask stays all ones. An eight-bit width lets distinct patterns in the latch and in the mask tell apart a held value from a newly loaded one.

// File: rtl/dram_io_pkg.sv
package dram_io_pkg;

   // Path state: closed, open for reading, or inside a write cycle
   typedef enum logic [1:0] {
      PATH_SHUT  = 2'd0,
      PATH_READ  = 2'd1,
      PATH_WRITE = 2'd2
   } path_st_t;

   // Strobe events derived from consecutive samples
   typedef struct packed {
      logic row_fall;
      logic row_rise;
      logic col_fall;
      logic row_held;   // row strobe was low at the previous edge too
   } strobe_ev_t;

endpackage

// File: rtl/io_strobe_edges.sv
module io_strobe_edges
   import dram_io_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n,
   input  logic       cas_n,
   output strobe_ev_t ev
);

   logic ras_q;
   logic cas_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= 1'b1;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
      end
   end

   always_comb begin
      ev.row_fall = ras_q & ~ras_n;
      ev.row_rise = ~ras_q & ras_n;
      ev.col_fall = cas_q & ~cas_n;
      ev.row_held = ~ras_q;
   end

endmodule

// File: rtl/io_path_fsm.sv
module io_path_fsm
   import dram_io_pkg::*;
#(
   parameter bit EXT_HOLD = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   input  logic     col_fall,
   output path_st_t st
);

   logic     close_now;
   path_st_t st_nx;

   generate
      if (EXT_HOLD) begin : g_hold
         // drivers remain until both strobes are high
         assign close_now = ras_n & cas_n;
      end else begin : g_page
         assign close_now = cas_n;
      end
   endgenerate

   always_comb begin
      st_nx = st;
      if (close_now) begin
         st_nx = PATH_SHUT;
      end else begin
         unique case (st)
            PATH_SHUT: begin
               if (col_fall && !ras_n)
                  st_nx = we_n ? PATH_READ : PATH_WRITE;
            end
            PATH_READ: begin
               if (!ras_n && !cas_n && !we_n)
                  st_nx = PATH_WRITE;
            end
            PATH_WRITE: st_nx = PATH_WRITE;
            default:    st_nx = PATH_SHUT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= PATH_SHUT;
      else        st <= st_nx;
   end

   // R3: a column edge with the row strobe high never opens the path
   a_r3_no_open_row_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && st == PATH_SHUT) |=> (st == PATH_SHUT));

   // R5: both strobes high always closes the path
   a_r5_close_both_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && cas_n) |=> (st == PATH_SHUT));

endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R11, R4: without a load the latch keeps its contents
   a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/io_wmask.sv
module io_wmask #(
   parameter int DW         = 8,
   parameter bit PER_BIT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          row_fall,
   input  logic          row_rise,
   input  logic          we_n,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] mask
);

   localparam logic [DW-1:0] ALL_ON = {DW{1'b1}};

   generate
      if (PER_BIT_EN) begin : g_mask
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask <= ALL_ON;
            else if (row_fall)
               mask <= we_n ? ALL_ON : pin_in;
            else if (row_rise)
               mask <= ALL_ON;
         end
      end else begin : g_nomask
         logic unused_in;
         assign unused_in = ^{clk, rst_n, row_fall, row_rise, we_n, pin_in};
         assign mask = ALL_ON;
      end
   endgenerate

   // R10: the mask never outlives its row cycle
   a_r10_mask_restore: assert property (@(posedge clk) disable iff (!rst_n)
      row_rise |=> (mask == ALL_ON));

endmodule

// File: rtl/dram_io_ctl.sv
module dram_io_ctl
   import dram_io_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit EXT_HOLD   = 1'b1,
   parameter bit PER_BIT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ras_n,
   input  logic          cas_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [DW-1:0] rd_data,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] dout,
   output logic          dout_en,
   output logic [DW-1:0] wmask,
   output logic [DW-1:0] bit_we
);

   localparam logic [DW-1:0] NONE = '0;

   generate
      if (DW < 1) begin : g_bad_width
         $error("dram_io_ctl: DW must be at least 1");
      end
   endgenerate

   strobe_ev_t ev;
   path_st_t   st;
   logic       rd_load;
   logic       wr_now;

   io_strobe_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .ev    (ev)
   );

   io_path_fsm #(.EXT_HOLD(EXT_HOLD)) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .col_fall (ev.col_fall),
      .st       (st)
   );

   assign rd_load = ev.col_fall & ~ras_n & we_n;

   io_out_latch #(.DW(DW)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_load),
      .d     (rd_data),
      .q     (dout)
   );

   io_wmask #(.DW(DW), .PER_BIT_EN(PER_BIT_EN)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_fall (ev.row_fall),
      .row_rise (ev.row_rise),
      .we_n     (we_n),
      .pin_in   (pin_in),
      .mask     (wmask)
   );

   assign dout_en = (st == PATH_READ) & ~oe_n & we_n;
   assign wr_now  = ev.row_held & ~ras_n & ~cas_n & ~we_n;
   assign bit_we  = wr_now ? wmask : NONE;

   // R8: a write never touches a bit the mask protects
   a_r8_bwe_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ((bit_we & ~wmask) == NONE));

   // R7: drivers are off for any cycle spent inside a write
   a_r7_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PATH_WRITE) |-> !dout_en);

endmodule

// File: tb/tb_dram_io_ctl.sv
module tb_dram_io_ctl;

   localparam int DW = 8;
   localparam int NV = 23;

   typedef struct packed {
      logic [23:0]   tag;
      logic          r, c, w, o;
      logic [DW-1:0] rd, pin;
      logic          en, fpen;
      logic [DW-1:0] dq, bwe, msk;
   } vec_t;

   // inputs applied, then outputs expected after the next clock edge
   localparam vec_t VEC [NV] = '{
      '{"R1 ",1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,8'h00,8'h00,8'hFF},
      '{"R3 ",1'b1,1'b0,1'b1,1'b0,8'h11,8'h00,1'b0,1'b0,8'h00,8'h00,8'hFF},
      '{"R3 ",1'b1,1'b1,1'b1,1'b0,8'h11,8'h00,1'b0,1'b0,8'h00,8'h00,8'hFF},
      '{"R9 ",1'b0,1'b1,1'b1,1'b0,8'h22,8'h00,1'b0,1'b0,8'h00,8'h00,8'hFF},
      '{"R2 ",1'b0,1'b0,1'b1,1'b0,8'hA5,8'h00,1'b1,1'b1,8'hA5,8'h00,8'hFF},
      '{"R4 ",1'b0,1'b1,1'b1,1'b0,8'h3C,8'h00,1'b1,1'b0,8'hA5,8'h00,8'hFF},
      '{"R2 ",1'b0,1'b0,1'b1,1'b0,8'h5A,8'h00,1'b1,1'b1,8'h5A,8'h00,8'hFF},
      '{"R6 ",1'b0,1'b0,1'b1,1'b1,8'h66,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R6 ",1'b0,1'b0,1'b1,1'b0,8'h66,8'h00,1'b1,1'b1,8'h5A,8'h00,8'hFF},
      '{"R5 ",1'b1,1'b0,1'b1,1'b0,8'h77,8'h00,1'b1,1'b1,8'h5A,8'h00,8'hFF},
      '{"R5 ",1'b1,1'b1,1'b1,1'b0,8'h77,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R7 ",1'b1,1'b1,1'b0,1'b0,8'h00,8'hF0,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R8 ",1'b0,1'b1,1'b0,1'b0,8'h00,8'h3C,1'b0,1'b0,8'h5A,8'h00,8'h3C},
      '{"R8 ",1'b0,1'b0,1'b0,1'b0,8'h99,8'h00,1'b0,1'b0,8'h5A,8'h3C,8'h3C},
      '{"R7 ",1'b0,1'b0,1'b1,1'b0,8'h99,8'h00,1'b0,1'b0,8'h5A,8'h00,8'h3C},
      '{"R7 ",1'b0,1'b1,1'b1,1'b0,8'h99,8'h00,1'b0,1'b0,8'h5A,8'h00,8'h3C},
      '{"R10",1'b1,1'b1,1'b1,1'b0,8'h99,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R9 ",1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R11",1'b0,1'b0,1'b0,1'b0,8'h44,8'h00,1'b0,1'b0,8'h5A,8'hFF,8'hFF},
      '{"R7 ",1'b0,1'b1,1'b1,1'b0,8'h44,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R5 ",1'b1,1'b1,1'b1,1'b0,8'h44,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R9 ",1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,8'h5A,8'h00,8'hFF},
      '{"R2 ",1'b0,1'b0,1'b1,1'b0,8'hC3,8'h00,1'b1,1'b1,8'hC3,8'h00,8'hFF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] rd_data = '0, pin_in = '0;
   logic [DW-1:0] dout, wmask, bit_we;
   logic          dout_en;
   logic [DW-1:0] fp_dout, fp_wmask, fp_bit_we;
   logic          fp_dout_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   dram_io_ctl #(.DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .rd_data(rd_data), .pin_in(pin_in), .dout(dout),
      .dout_en(dout_en), .wmask(wmask), .bit_we(bit_we)
   );

   dram_io_ctl #(.DW(DW), .EXT_HOLD(1'b0), .PER_BIT_EN(1'b0)) dut_fp (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .rd_data(rd_data), .pin_in(pin_in), .dout(fp_dout),
      .dout_en(fp_dout_en), .wmask(fp_wmask), .bit_we(fp_bit_we)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "dout_en in reset", {7'd0, dout_en}, 8'h00);
      check("R1", "dout in reset", dout, 8'h00);
      check("R1", "wmask in reset", wmask, 8'hFF);
      check("R1", "bit_we in reset", bit_we, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ras_n = VEC[i].r; cas_n = VEC[i].c; we_n = VEC[i].w; oe_n = VEC[i].o;
         rd_data = VEC[i].rd; pin_in = VEC[i].pin;
         step();
         check(string'(VEC[i].tag), $sformatf("dout_en vec %0d", i),
               {7'd0, dout_en}, {7'd0, VEC[i].en});
         check(string'(VEC[i].tag), $sformatf("dout vec %0d", i), dout, VEC[i].dq);
         check(string'(VEC[i].tag), $sformatf("bit_we vec %0d", i), bit_we, VEC[i].bwe);
         check(string'(VEC[i].tag), $sformatf("wmask vec %0d", i), wmask, VEC[i].msk);
         check("R12", $sformatf("fast-page dout_en vec %0d", i),
               {7'd0, fp_dout_en}, {7'd0, VEC[i].fpen});
         check("R13", $sformatf("fixed mask vec %0d", i), fp_wmask, 8'hFF);
         if (i == 13)
            check("R13", "fixed-mask write enables", fp_bit_we, 8'hFF);
      end
      // R1: reset in the middle of an open read
      @(negedge clk);
      rst_n = 1'b0;
      step();
      check("R1", "dout_en after mid reset", {7'd0, dout_en}, 8'h00);
      check("R1", "dout after mid reset", dout, 8'h00);
      check("R1", "wmask after mid reset", wmask, 8'hFF);
      check("R1", "bit_we after mid reset", bit_we, 8'h00);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule